// File: doc/BRIEF.md
# Translation Cache with Pinned Entries

This block is a small fully associative cache of address translations. Each slot pairs a virtual page number with a physical frame number. A lookup presents a page number, and the block compares it against every slot at once. In the same cycle it returns a hit flag and the matching frame number. When a lookup misses, an external page-table walker fetches the translation and installs it through the fill port.

A control side can pin individual slots, so that replacement and flushing never touch them. It can also invalidate every unpinned slot in a single cycle. A fill first takes any empty slot. When no slot is empty, it evicts the unpinned slot that was used least recently. A hit or a fill counts as a use.

When every slot is pinned, a fill has nowhere to go. The block drops it and raises an error flag for one cycle. Only one command is acted on per cycle, in this order of priority: flush first, then pin or unpin, then fill. Lookups run alongside any command.

Top module: `tlb_wired`

## Requirements
- R1: After reset every slot is empty, so every lookup misses and `full_err` is low.
- R2: A lookup whose page number matches a valid slot sets `lk_hit` and drives that slot's frame number on `lk_pfn` in the same cycle. A lookup with no match drives `lk_hit` low and `lk_pfn` zero.
- R3: After a fill that is accepted, a lookup of the filled page number hits and returns the filled frame number.
- R4: A fill of a new page number goes to an empty slot whenever one exists, and no valid slot is displaced.
- R5: When no slot is empty, a fill of a new page number replaces the valid unpinned slot whose last hit or fill is the oldest.
- R6: A fill of a page number that is already present overwrites that slot's frame number in place. No second slot is created for that page number.
- R7: A pinned slot is never chosen for replacement. A pin command with `wire_set` at 1 pins the valid slot that matches `wire_vpn`, and with `wire_set` at 0 it unpins that slot.
- R8: A flush empties every unpinned slot in one cycle, and pinned slots stay valid. A fill or pin command presented in the same cycle is ignored.
- R9: A fill of a new page number while every slot is pinned is dropped. `full_err` is then high for exactly the one cycle that follows that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request; a hit counts as a use for recency |
| lk_vpn | input | VPN_W | Page number to translate |
| lk_hit | output | 1 | Lookup matched a valid slot |
| lk_pfn | output | PFN_W | Frame number of the matching slot, zero on a miss |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | VPN_W | Page number to install |
| fill_pfn | input | PFN_W | Frame number to install |
| fill_wired | input | 1 | Pin the installed slot |
| flush | input | 1 | Empty all unpinned slots |
| wire_en | input | 1 | Pin or unpin command |
| wire_vpn | input | VPN_W | Page number whose slot is pinned or unpinned |
| wire_set | input | 1 | 1 pins, 0 unpins |
| full_err | output | 1 | One-cycle pulse after a fill is dropped |

## Verification
Lookups are issued in three patterns: in fill order, which leaves the recency order unchanged; out of order, which moves one slot to most recent; and to page numbers that are absent. Comparing these separates a victim chosen by age from one chosen by slot position. Fills are tried into a partly empty cache, a full cache, and a full cache with pins. These cases show whether empty slots are preferred, whether pinned slots are skipped, and whether a fill with nowhere to go is dropped with the error pulse. Repeated fills of a page number already present, and flushes with different pin sets, show that fills update in place and that a flush leaves pinned slots valid.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_FLUSH = 2'd1,
    CMD_WIRE  = 2'd2,
    CMD_FILL  = 2'd3
  } tlb_cmd_e;

  localparam int NPROBE     = 3;
  localparam int PROBE_LK   = 0;
  localparam int PROBE_FILL = 1;
  localparam int PROBE_WIRE = 2;
endpackage

// File: rtl/tlb_match.sv
// Compares one page number against all slot keys at once.
module tlb_match #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0]            valid,
  input  logic [ENTRIES-1:0][VPN_W-1:0] keys,
  input  logic [VPN_W-1:0]              vpn,
  output logic [ENTRIES-1:0]            hit_vec,
  output logic [IDX_W-1:0]              hit_idx
);
  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign hit_vec[e] = valid[e] && (keys[e] == vpn);
  end

  // Keys are unique among valid slots, so OR-ing the indices is exact.
  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) hit_idx = hit_idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_lru.sv
// Keeps one age per slot. The ages always form a permutation:
// 0 is the most recent, ENTRIES-1 the oldest.
module tlb_lru #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            touch_a_en,
  input  logic [IDX_W-1:0]                touch_a_idx,
  input  logic                            touch_b_en,
  input  logic [IDX_W-1:0]                touch_b_idx,
  output logic [ENTRIES-1:0][IDX_W-1:0]   ages
);
  typedef logic [ENTRIES-1:0][IDX_W-1:0] age_vec_t;

  age_vec_t ages_q, ages_mid, ages_d;
  logic     ages_en;

  function automatic age_vec_t touch(input age_vec_t cur, input logic [IDX_W-1:0] k);
    age_vec_t nxt;
    nxt = cur;
    for (int i = 0; i < ENTRIES; i++) begin
      if (cur[i] < cur[k]) nxt[i] = cur[i] + 1'b1;
    end
    nxt[k] = '0;
    return nxt;
  endfunction

  // A lookup hit is applied first, then a fill, so the fill ends most recent.
  always_comb begin
    ages_mid = touch_a_en ? touch(ages_q, touch_a_idx) : ages_q;
    ages_d   = touch_b_en ? touch(ages_mid, touch_b_idx) : ages_mid;
    ages_en  = touch_a_en || touch_b_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ages_q[i] <= IDX_W'(i);
    end else if (ages_en) begin
      ages_q <= ages_d;
    end
  end

  assign ages = ages_q;
endmodule

// File: rtl/tlb_victim.sv
// Chooses the slot a fill of a new page number goes to.
module tlb_victim #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0]            valid,
  input  logic [ENTRIES-1:0]            wired,
  input  logic [ENTRIES-1:0][IDX_W-1:0] ages,
  output logic [IDX_W-1:0]              victim_idx,
  output logic                          victim_ok
);
  logic             free_ok, old_ok;
  logic [IDX_W-1:0] free_idx, old_idx, old_age;

  always_comb begin
    // Lowest-numbered empty slot.
    free_ok  = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        free_ok  = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
    // Oldest valid unpinned slot.
    old_ok  = 1'b0;
    old_idx = '0;
    old_age = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (valid[i] && !wired[i] && (!old_ok || ages[i] > old_age)) begin
        old_ok  = 1'b1;
        old_idx = IDX_W'(i);
        old_age = ages[i];
      end
    end
    victim_ok  = free_ok || old_ok;
    victim_idx = free_ok ? free_idx : old_idx;
  end
endmodule

// File: rtl/tlb_wired.sv
module tlb_wired #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             fill_wired,
  input  logic             flush,
  input  logic             wire_en,
  input  logic [VPN_W-1:0] wire_vpn,
  input  logic             wire_set,
  output logic             full_err
);
  import tlb_pkg::*;

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]            valid_q, valid_d;
  logic [ENTRIES-1:0]            wired_q, wired_d;
  logic [ENTRIES-1:0][VPN_W-1:0] key_q;
  logic [ENTRIES-1:0][PFN_W-1:0] pfn_q;
  logic                          err_q, err_d;

  logic [NPROBE-1:0][VPN_W-1:0]   probe_vpn;
  logic [NPROBE-1:0][ENTRIES-1:0] probe_vec;
  logic [NPROBE-1:0][IDX_W-1:0]   probe_idx;
  logic [NPROBE-1:0]              probe_hit;

  logic [ENTRIES-1:0][IDX_W-1:0] ages;
  logic [IDX_W-1:0]              victim_idx;
  logic                          victim_ok;

  tlb_cmd_e         cmd;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;

  // One matcher per page-number source: lookup, fill, pin command.
  assign probe_vpn[PROBE_LK]   = lk_vpn;
  assign probe_vpn[PROBE_FILL] = fill_vpn;
  assign probe_vpn[PROBE_WIRE] = wire_vpn;

  for (genvar p = 0; p < NPROBE; p++) begin : g_probe
    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_match (
      .valid   (valid_q),
      .keys    (key_q),
      .vpn     (probe_vpn[p]),
      .hit_vec (probe_vec[p]),
      .hit_idx (probe_idx[p])
    );
    assign probe_hit[p] = |probe_vec[p];
  end

  tlb_lru #(.ENTRIES(ENTRIES)) u_lru (
    .clk         (clk),
    .rst_n       (rst_n),
    .touch_a_en  (lk_valid && probe_hit[PROBE_LK]),
    .touch_a_idx (probe_idx[PROBE_LK]),
    .touch_b_en  (wr_en),
    .touch_b_idx (wr_idx),
    .ages        (ages)
  );

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .valid      (valid_q),
    .wired      (wired_q),
    .ages       (ages),
    .victim_idx (victim_idx),
    .victim_ok  (victim_ok)
  );

  // Lookup result, combinational.
  assign lk_hit = lk_valid && probe_hit[PROBE_LK];
  assign lk_pfn = lk_hit ? pfn_q[probe_idx[PROBE_LK]] : '0;

  // One command per cycle.
  always_comb begin
    if (flush)           cmd = CMD_FLUSH;
    else if (wire_en)    cmd = CMD_WIRE;
    else if (fill_valid) cmd = CMD_FILL;
    else                 cmd = CMD_NONE;
  end

  // Next state.
  always_comb begin
    valid_d = valid_q;
    wired_d = wired_q;
    err_d   = 1'b0;
    wr_en   = 1'b0;
    wr_idx  = '0;
    unique case (cmd)
      CMD_FLUSH: valid_d = valid_q & wired_q;
      CMD_WIRE: begin
        if (probe_hit[PROBE_WIRE]) wired_d[probe_idx[PROBE_WIRE]] = wire_set;
      end
      CMD_FILL: begin
        if (probe_hit[PROBE_FILL]) begin
          wr_en  = 1'b1;
          wr_idx = probe_idx[PROBE_FILL];
        end else if (victim_ok) begin
          wr_en  = 1'b1;
          wr_idx = victim_idx;
          wired_d[victim_idx] = 1'b0;
        end else begin
          err_d = 1'b1;
        end
        if (wr_en) begin
          valid_d[wr_idx] = 1'b1;
          if (fill_wired) wired_d[wr_idx] = 1'b1;
        end
      end
      default: ;
    endcase
  end

  // Control registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      wired_q <= '0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      wired_q <= wired_d;
      err_q   <= err_d;
    end
  end

  // Data registers, without reset, written only on an accepted fill.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      key_q[wr_idx] <= fill_vpn;
      pfn_q[wr_idx] <= fill_pfn;
    end
  end

  assign full_err = err_q;
endmodule

// File: rtl/tlb_wired_chk.sv
module tlb_wired_chk #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            flush,
  input logic                            wire_en,
  input logic                            fill_valid,
  input logic [VPN_W-1:0]                fill_vpn,
  input logic                            full_err,
  input logic [ENTRIES-1:0]              valid_q,
  input logic [ENTRIES-1:0]              wired_q,
  input logic [ENTRIES-1:0][VPN_W-1:0]   key_q,
  input logic [ENTRIES-1:0]              hit_vec
);
  logic             fill_go;
  logic [VPN_W-1:0] fill_vpn_q;
  logic             dup, found;

  assign fill_go = fill_valid && !flush && !wire_en;

  always_ff @(posedge clk) fill_vpn_q <= fill_vpn;

  always_comb begin
    dup   = 1'b0;
    found = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (valid_q[i] && key_q[i] == fill_vpn_q) found = 1'b1;
      for (int j = i + 1; j < ENTRIES; j++) begin
        if (valid_q[i] && valid_q[j] && key_q[i] == key_q[j]) dup = 1'b1;
      end
    end
  end

  assert_hit_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  assert_fill_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_go |=> (full_err || found));

  assert_no_dup_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !dup);

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ((valid_q & ~wired_q) == '0));

  assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    full_err |-> ($past(fill_go) && ((valid_q & wired_q) == {ENTRIES{1'b1}})));

  for (genvar e = 0; e < ENTRIES; e++) begin : g_pin
    assert_pinned_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q[e] && wired_q[e]) |=> (valid_q[e] && $stable(key_q[e])));
  end
endmodule

bind tlb_wired tlb_wired_chk #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush      (flush),
  .wire_en    (wire_en),
  .fill_valid (fill_valid),
  .fill_vpn   (fill_vpn),
  .full_err   (full_err),
  .valid_q    (valid_q),
  .wired_q    (wired_q),
  .key_q      (key_q),
  .hit_vec    (probe_vec[0])
);

// File: tb/sim_tlb_wired.sv
`timescale 1ns/1ps
module sim_tlb_wired;
  localparam int ENTRIES = 4;
  localparam int VPN_W   = 8;
  localparam int PFN_W   = 8;

  localparam logic [2:0] OP_LK = 3'd0;
  localparam logic [2:0] OP_FL = 3'd1;
  localparam logic [2:0] OP_FH = 3'd2;
  localparam logic [2:0] OP_WS = 3'd3;
  localparam logic [2:0] OP_WC = 3'd4;

  typedef struct packed {
    logic [2:0] op;
    logic [7:0] vpn;
    logic [7:0] pfn;
    logic       hit;
    logic       err;
    logic [3:0] req;
  } step_t;

  localparam int NSTEPS = 41;
  localparam step_t STEPS [NSTEPS] = '{
    '{OP_LK, 8'h10, 8'h00, 1'b0, 1'b0, 4'd1}, // R1 empty after reset
    '{OP_FL, 8'h10, 8'hA0, 1'b0, 1'b0, 4'd3}, // R3
    '{OP_FL, 8'h11, 8'hA1, 1'b0, 1'b0, 4'd3},
    '{OP_FL, 8'h12, 8'hA2, 1'b0, 1'b0, 4'd3},
    '{OP_FL, 8'h13, 8'hA3, 1'b0, 1'b0, 4'd3},
    '{OP_LK, 8'h10, 8'hA0, 1'b1, 1'b0, 4'd2}, // R2
    '{OP_LK, 8'h11, 8'hA1, 1'b1, 1'b0, 4'd4}, // R4 all four fills kept
    '{OP_LK, 8'h12, 8'hA2, 1'b1, 1'b0, 4'd4},
    '{OP_LK, 8'h13, 8'hA3, 1'b1, 1'b0, 4'd4},
    '{OP_LK, 8'h10, 8'hA0, 1'b1, 1'b0, 4'd5}, // R5 make 10 newest
    '{OP_FL, 8'h14, 8'hB4, 1'b0, 1'b0, 4'd5}, // R5 evicts 11
    '{OP_LK, 8'h11, 8'h00, 1'b0, 1'b0, 4'd5},
    '{OP_LK, 8'h14, 8'hB4, 1'b1, 1'b0, 4'd5},
    '{OP_LK, 8'h12, 8'hA2, 1'b1, 1'b0, 4'd5},
    '{OP_FL, 8'h10, 8'hC0, 1'b0, 1'b0, 4'd6}, // R6 update in place
    '{OP_LK, 8'h10, 8'hC0, 1'b1, 1'b0, 4'd6},
    '{OP_WS, 8'h13, 8'h00, 1'b0, 1'b0, 4'd7}, // R7 pin oldest
    '{OP_FL, 8'h15, 8'hD5, 1'b0, 1'b0, 4'd7}, // R7 evicts 14, not 13
    '{OP_LK, 8'h14, 8'h00, 1'b0, 1'b0, 4'd7},
    '{OP_LK, 8'h13, 8'hA3, 1'b1, 1'b0, 4'd7},
    '{OP_FH, 8'h00, 8'h00, 1'b0, 1'b0, 4'd8}, // R8 flush
    '{OP_LK, 8'h12, 8'h00, 1'b0, 1'b0, 4'd8},
    '{OP_LK, 8'h15, 8'h00, 1'b0, 1'b0, 4'd8},
    '{OP_LK, 8'h13, 8'hA3, 1'b1, 1'b0, 4'd8},
    '{OP_FL, 8'h20, 8'hE0, 1'b0, 1'b0, 4'd4}, // R4 refill empties
    '{OP_FL, 8'h21, 8'hE1, 1'b0, 1'b0, 4'd4},
    '{OP_FL, 8'h22, 8'hE2, 1'b0, 1'b0, 4'd4},
    '{OP_LK, 8'h13, 8'hA3, 1'b1, 1'b0, 4'd4},
    '{OP_WS, 8'h20, 8'h00, 1'b0, 1'b0, 4'd7},
    '{OP_WS, 8'h21, 8'h00, 1'b0, 1'b0, 4'd7},
    '{OP_WS, 8'h22, 8'h00, 1'b0, 1'b0, 4'd7},
    '{OP_FL, 8'h23, 8'hF3, 1'b0, 1'b1, 4'd9}, // R9 all pinned
    '{OP_LK, 8'h23, 8'h00, 1'b0, 1'b0, 4'd9},
    '{OP_LK, 8'h20, 8'hE0, 1'b1, 1'b0, 4'd9},
    '{OP_FH, 8'h00, 8'h00, 1'b0, 1'b0, 4'd8}, // R8 flush, all pinned
    '{OP_LK, 8'h21, 8'hE1, 1'b1, 1'b0, 4'd8},
    '{OP_WC, 8'h21, 8'h00, 1'b0, 1'b0, 4'd7}, // R7 unpin 21
    '{OP_FL, 8'h23, 8'hF3, 1'b0, 1'b0, 4'd7}, // R7 only 21 can go
    '{OP_LK, 8'h21, 8'h00, 1'b0, 1'b0, 4'd7},
    '{OP_LK, 8'h23, 8'hF3, 1'b1, 1'b0, 4'd7},
    '{OP_LK, 8'h22, 8'hE2, 1'b1, 1'b0, 4'd7}
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             lk_valid, fill_valid, fill_wired, flush, wire_en, wire_set;
  logic [VPN_W-1:0] lk_vpn, fill_vpn, wire_vpn;
  logic [PFN_W-1:0] fill_pfn;
  logic             lk_hit, full_err;
  logic [PFN_W-1:0] lk_pfn;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  tlb_wired #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_pfn(lk_pfn),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_wired(fill_wired), .flush(flush),
    .wire_en(wire_en), .wire_vpn(wire_vpn), .wire_set(wire_set),
    .full_err(full_err)
  );

  task automatic check(input logic ok, input int req, input int step,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d step %0d: actual %h expected %h", req, step, act, exp);
    end
  endtask

  task automatic idle_inputs();
    lk_valid = 1'b0; lk_vpn = '0;
    fill_valid = 1'b0; fill_vpn = '0; fill_pfn = '0; fill_wired = 1'b0;
    flush = 1'b0; wire_en = 1'b0; wire_vpn = '0; wire_set = 1'b0;
  endtask

  task automatic run_step(input step_t s, input int idx);
    @(negedge clk);
    idle_inputs();
    case (s.op)
      OP_LK: begin lk_valid = 1'b1; lk_vpn = s.vpn; end
      OP_FL: begin fill_valid = 1'b1; fill_vpn = s.vpn; fill_pfn = s.pfn; end
      OP_FH: flush = 1'b1;
      OP_WS: begin wire_en = 1'b1; wire_vpn = s.vpn; wire_set = 1'b1; end
      default: begin wire_en = 1'b1; wire_vpn = s.vpn; wire_set = 1'b0; end
    endcase
    #2;
    if (s.op == OP_LK) begin
      check(lk_hit == s.hit, int'(s.req), idx, 16'(lk_hit), 16'(s.hit));
      check(lk_pfn == (s.hit ? s.pfn : 8'h00), int'(s.req), idx,
            16'(lk_pfn), 16'(s.hit ? s.pfn : 8'h00));
    end
    @(posedge clk);
    #1;
    check(full_err == s.err, int'(s.req), idx, 16'(full_err), 16'(s.err));
    idle_inputs();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired: actual %0d expected below 20000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    #1;
    // R1: reset state
    lk_valid = 1'b1; lk_vpn = 8'h10;
    #1;
    check(lk_hit == 1'b0, 1, -1, 16'(lk_hit), 16'd0);
    check(full_err == 1'b0, 1, -1, 16'(full_err), 16'd0);
    lk_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NSTEPS; i++) run_step(STEPS[i], i);

    // R8: fill in a flush cycle is ignored
    @(negedge clk);
    flush = 1'b1; fill_valid = 1'b1; fill_vpn = 8'h30; fill_pfn = 8'h77;
    @(posedge clk); #1;
    idle_inputs();
    @(negedge clk);
    lk_valid = 1'b1; lk_vpn = 8'h30;
    #2;
    check(lk_hit == 1'b0, 8, 100, 16'(lk_hit), 16'd0);
    lk_vpn = 8'h22;
    #1;
    check(lk_hit == 1'b1 && lk_pfn == 8'hE2, 8, 101, 16'(lk_pfn), 16'h00E2);
    idle_inputs();

    // R1: asynchronous reset mid-run empties every slot
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    lk_valid = 1'b1; lk_vpn = 8'h22;
    #1;
    check(lk_hit == 1'b0, 1, 102, 16'(lk_hit), 16'd0);
    check(lk_pfn == 8'h00, 1, 103, 16'(lk_pfn), 16'd0);
    check(full_err == 1'b0, 1, 104, 16'(full_err), 16'd0);
    idle_inputs();
    @(negedge clk);
    rst_n = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule